// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Wake Alarm

This block is the time-keeping register set of a power-sequencing companion device. A 32-bit count of seconds advances on each pulse of a one-second tick input, and a 32-bit alarm value is compared with that count. When the count reaches the alarm value, a sticky status bit is set, which drives the interrupt output. Depending on two enables in the control register, the same event can also produce a one-cycle wake request pulse and a one-cycle power-up request pulse.

Software reaches the block through a plain byte-wide register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Every strobe is accepted in the cycle it is presented, so the bus has no back-pressure and no ready signal. Read data appears one clock after the read strobe and holds until the next read.

Multi-byte values are handled one byte at a time:
- **Reading the count.** Read the most significant time byte first. That read snapshots the whole count, so the three lower bytes read afterwards belong to the same instant.
- **Writing the count.** Write the upper three time bytes first; these writes are only staged. Writing the least significant byte then loads all 32 bits at once.
- **Disabling the alarm.** An alarm value of all ones switches the alarm off.

Top module: `secs_rtc`

## Requirements
- R1: After reset the following hold:
  - the count is 0, the alarm is 0xFFFFFFFF and the control byte is 0x00;
  - the alarm status bit is clear, and `irq_o`, `wake_o`, `pwrup_o` and `rdata_o` are 0.
- R2: A cycle with `tick_i` high, and no write to address 0x73, adds one to the count. The count wraps from 0xFFFFFFFF to 0. The count holds when there is no tick and no load.
- R3: Time bytes sit at 0x70 (bits 31:24), 0x71 (bits 23:16), 0x72 (bits 15:8) and 0x73 (bits 7:0).
  - A read of 0x70 returns the live bits 31:24 and captures the whole count into a snapshot.
  - Reads of 0x71 to 0x73 return bytes of that snapshot, even if ticks arrived in between.
- R4: Writes to 0x70, 0x71 and 0x72 only stage a byte and leave the running count alone. A write to 0x73 loads the count from {staged 0x70, staged 0x71, staged 0x72, written byte}. If the load and a tick fall in the same cycle, the load wins.
- R5: The alarm bytes sit at 0x74 (bits 31:24), 0x75, 0x76 and 0x77 (bits 7:0). Each byte is written and read back directly.
- R6: An alarm event happens on a tick whose new count equals the alarm value. On the same clock edge, bit 3 of the status byte at 0x10 becomes 1 and `irq_o` goes high. Loading the count never causes an event.
- R7: While the alarm holds 0xFFFFFFFF, no event occurs, even when the count passes 0xFFFFFFFF.
- R8: Writing the status byte at 0x10 clears bit 3 where the written bit 3 is 1; writing 0 there leaves it set. An event in the same cycle as a clearing write keeps the bit set.
- R9: Control byte 0x29 reads back exactly as written.
  - Bit 3 enables a one-cycle `wake_o` pulse on each alarm event.
  - Bit 2 enables a one-cycle `pwrup_o` pulse on each alarm event.
  - Each pulse is asserted on the event edge.
  - Bits 7:4 hold a stored reset-delay value with no effect inside the block.
- R10: Reads of 0x00 return the vendor ID (default 0x5A) and reads of 0x01 return the model revision (default 0x41, at least 0x40). Status bytes 0x11 and 0x12, and all other unmapped addresses, read as 0x00. Writes to read-only addresses change nothing.
- R11: `rdata_o` is updated on the clock edge that samples `rd_en_i` high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse, one clock wide |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt, high while the alarm status bit is set |
| wake_o | output | 1 | Wake request pulse |
| pwrup_o | output | 1 | Power-up request pulse |

## Verification
The assertions assume the following about the inputs:
- every input is synchronous to `clk` and free of unknowns once reset is released;
- `tick_i` is a one-clock pulse;
- a bus strobe is a single-cycle event.

From these, a rise of `irq_o` can be traced to a tick in the previous cycle, and a fall can be traced to a clearing status write. The bench keeps within these assumptions: it changes every input only on the falling clock edge, issues at most one strobe per cycle, and pulses the tick for exactly one cycle.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  typedef logic [7:0] byte_t;
  typedef logic [7:0] addr_t;

  // Register addresses; the time and alarm groups are MSB-first by address.
  localparam addr_t A_VENDOR = 8'h00;
  localparam addr_t A_MODEL  = 8'h01;
  localparam addr_t A_STAT   = 8'h10;
  localparam addr_t A_CTRL   = 8'h29;
  localparam addr_t A_TIME   = 8'h70;
  localparam addr_t A_ALARM  = 8'h74;

  localparam int ALARM_BIT = 3;  // status bit flagging an alarm event
  localparam int WAKE_BIT  = 3;  // control enable: wake pulse
  localparam int PWR_BIT   = 2;  // control enable: power-up pulse

  // Byte idx of an nb-byte value, idx 0 being the most significant byte.
  function automatic byte_t pick_byte(input logic [63:0] v, input int idx, input int nb);
    return byte_t'(v >> (8 * (nb - 1 - idx)));
  endfunction
endpackage

// File: rtl/secs_rtc_counter.sv
module secs_rtc_counter
  import secs_rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  addr_t            addr_i,
  input  byte_t            wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             adv_o
);
  localparam int    NB    = CNT_W / 8;
  localparam addr_t LSB_A = A_TIME + addr_t'(NB - 1);

  byte_t            stage_q [NB-1];
  logic [CNT_W-1:0] load_val;
  logic             load;

  assign load  = wr_en_i && (addr_i == LSB_A);
  assign adv_o = tick_i && !load;

  // Upper bytes wait in the stage until the LSB write commits them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB - 1; i++) stage_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NB - 1; i++)
        if (addr_i == A_TIME + addr_t'(i)) stage_q[i] <= wdata_i;
    end
  end

  always_comb begin
    load_val = CNT_W'(wdata_i);
    for (int i = 0; i < NB - 1; i++) load_val[CNT_W-1-8*i -: 8] = stage_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (load)   cnt_o <= load_val;
    else if (tick_i) cnt_o <= cnt_o + CNT_W'(1);
  end

  // An MSB read freezes the whole count for the lower-byte reads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            snap_o <= '0;
    else if (rd_en_i && addr_i == A_TIME) snap_o <= cnt_o;
  end
endmodule

// File: rtl/secs_rtc_alarm.sv
module secs_rtc_alarm
  import secs_rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  addr_t            addr_i,
  input  byte_t            wdata_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wake_en_i,
  input  logic             pwr_en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] alm_o,
  output logic             stat_o,
  output logic             wake_o,
  output logic             pwr_o
);
  localparam int NB = CNT_W / 8;

  logic armed, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alm_o <= '1;
    else if (wr_en_i) begin
      for (int i = 0; i < NB; i++)
        if (addr_i == A_ALARM + addr_t'(i)) alm_o[CNT_W-1-8*i -: 8] <= wdata_i;
    end
  end

  // Compare against the value the count takes on this tick.
  assign armed = (alm_o != '1);
  assign fire  = adv_i && armed && ((cnt_i + CNT_W'(1)) == alm_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o <= 1'b0;
      wake_o <= 1'b0;
      pwr_o  <= 1'b0;
    end else begin
      if (fire)       stat_o <= 1'b1;
      else if (clr_i) stat_o <= 1'b0;
      wake_o <= fire && wake_en_i;
      pwr_o  <= fire && pwr_en_i;
    end
  end
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int         CNT_W     = 32,
  parameter logic [7:0] VENDOR_ID = 8'h5A,
  parameter logic [7:0] MODEL_REV = 8'h41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       wake_o,
  output logic       pwrup_o
);
  localparam int NB = CNT_W / 8;

  logic [CNT_W-1:0] cnt_q, snap_q, alm_q;
  logic             adv, stat_q, clr;
  byte_t            ctrl_q, rd_val;

  secs_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cnt_o(cnt_q), .snap_o(snap_q), .adv_o(adv)
  );

  assign clr = wr_en_i && (addr_i == A_STAT) && wdata_i[ALARM_BIT];

  secs_rtc_alarm #(.CNT_W(CNT_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .adv_i(adv), .cnt_i(cnt_q), .wake_en_i(ctrl_q[WAKE_BIT]), .pwr_en_i(ctrl_q[PWR_BIT]),
    .clr_i(clr), .alm_o(alm_q), .stat_o(stat_q), .wake_o(wake_o), .pwr_o(pwrup_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            ctrl_q <= '0;
    else if (wr_en_i && addr_i == A_CTRL) ctrl_q <= wdata_i;
  end

  always_comb begin
    rd_val = '0;
    case (addr_i)
      A_VENDOR: rd_val = VENDOR_ID;
      A_MODEL:  rd_val = MODEL_REV;
      A_STAT:   rd_val[ALARM_BIT] = stat_q;
      A_CTRL:   rd_val = ctrl_q;
      default: begin
        if (addr_i == A_TIME)
          rd_val = pick_byte(64'(cnt_q), 0, NB);
        else if (addr_i > A_TIME && addr_i < A_TIME + addr_t'(NB))
          rd_val = pick_byte(64'(snap_q), 32'(addr_i - A_TIME), NB);
        else if (addr_i >= A_ALARM && addr_i < A_ALARM + addr_t'(NB))
          rd_val = pick_byte(64'(alm_q), 32'(addr_i - A_ALARM), NB);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  assign irq_o = stat_q;
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk
  import secs_rtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic [7:0]       addr_i,
  input logic             wbit3,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] alm_q,
  input logic             wake_en,
  input logic             pwr_en,
  input logic             irq_o,
  input logic             wake_o,
  input logic             pwrup_o
);
  localparam addr_t LSB_A = A_TIME + addr_t'(CNT_W / 8 - 1);

  assert_tick_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !(wr_en_i && addr_i == LSB_A)) |=> cnt_q == CNT_W'($past(cnt_q) + 1));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> $stable(cnt_q));
  assert_event_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(tick_i));
  assert_off_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(alm_q) != '1);
  assert_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(wr_en_i && addr_i == A_STAT && wbit3));
  assert_wake_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(wake_en) && irq_o));
  assert_pwr_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwrup_o |-> ($past(pwr_en) && irq_o));
  assert_wake_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
endmodule

bind secs_rtc secs_rtc_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i), .wbit3(wdata_i[3]),
  .wr_en_i(wr_en_i), .cnt_q(cnt_q), .alm_q(alm_q), .wake_en(ctrl_q[3]),
  .pwr_en(ctrl_q[2]), .irq_o(irq_o), .wake_o(wake_o), .pwrup_o(pwrup_o)
);

// File: tb/secs_rtc_tb_top.sv
`timescale 1ns/1ps
module secs_rtc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wd = '0;
  logic [7:0] rdata;
  logic irq, wake, pwr;

  int n_cmp = 0, n_bad = 0, n_wake = 0, n_pwr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  secs_rtc dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .addr_i(addr), .wdata_i(wd),
    .wr_en_i(wr), .rd_en_i(rd), .rdata_o(rdata), .irq_o(irq), .wake_o(wake), .pwrup_o(pwr)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cnt, m_snap, m_alm;
  logic [7:0]  m_st0, m_st1, m_st2, m_ctrl, m_rdata;
  logic        m_stat, m_wake, m_pwr, m_ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_snap = 0; m_alm = 32'hFFFF_FFFF;
      m_st0 = 0; m_st1 = 0; m_st2 = 0; m_ctrl = 0; m_rdata = 0;
      m_stat = 0; m_wake = 0; m_pwr = 0;
    end else begin
      if (rd) begin
        case (addr)
          8'h00: m_rdata = 8'h5A;
          8'h01: m_rdata = 8'h41;
          8'h10: m_rdata = {4'b0, m_stat, 3'b0};
          8'h29: m_rdata = m_ctrl;
          8'h70: begin m_rdata = m_cnt[31:24]; m_snap = m_cnt; end
          8'h71: m_rdata = m_snap[23:16];
          8'h72: m_rdata = m_snap[15:8];
          8'h73: m_rdata = m_snap[7:0];
          8'h74: m_rdata = m_alm[31:24];
          8'h75: m_rdata = m_alm[23:16];
          8'h76: m_rdata = m_alm[15:8];
          8'h77: m_rdata = m_alm[7:0];
          default: m_rdata = 8'h00;
        endcase
      end
      m_ev = 1'b0;
      if (wr && addr == 8'h73) m_cnt = {m_st0, m_st1, m_st2, wd};
      else if (tick) begin
        m_cnt = m_cnt + 1;
        m_ev = (m_alm != 32'hFFFF_FFFF) && (m_cnt == m_alm);
      end
      m_wake = m_ev && m_ctrl[3];
      m_pwr  = m_ev && m_ctrl[2];
      if (m_ev) m_stat = 1'b1;
      else if (wr && addr == 8'h10 && wd[3]) m_stat = 1'b0;
      if (wr) begin
        case (addr)
          8'h70: m_st0 = wd;
          8'h71: m_st1 = wd;
          8'h72: m_st2 = wd;
          8'h74: m_alm[31:24] = wd;
          8'h75: m_alm[23:16] = wd;
          8'h76: m_alm[15:8] = wd;
          8'h77: m_alm[7:0] = wd;
          8'h29: m_ctrl = wd;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rdata == m_rdata, "R11 rdata", rdata, m_rdata);
      check(irq == m_stat, "R6 irq_o", irq, m_stat);
      check(wake == m_wake, "R9 wake_o", wake, m_wake);
      check(pwr == m_pwr, "R9 pwrup_o", pwr, m_pwr);
    end
  end

  always @(posedge clk) begin
    if (wake) n_wake++;
    if (pwr) n_pwr++;
  end

  // One bus cycle, entered and left on a falling edge.
  task automatic cyc(input logic t, input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
    tick = t; wr = w; rd = r; addr = a; wd = d;
    @(negedge clk);
    tick = 0; wr = 0; rd = 0;
  endtask
  task automatic wrb(input logic [7:0] a, input logic [7:0] d); cyc(0, 1, 0, a, d); endtask
  task automatic idle(); cyc(0, 0, 0, 8'h00, 8'h00); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) cyc(1, 0, 0, 8'h00, 8'h00); endtask
  task automatic rdb(input logic [7:0] a, input logic [7:0] exp, input string tag);
    cyc(0, 0, 1, a, 8'h00);
    check(rdata == exp, tag, rdata, exp);
  endtask
  task automatic set_time(input logic [31:0] v);
    wrb(8'h70, v[31:24]); wrb(8'h71, v[23:16]); wrb(8'h72, v[15:8]); wrb(8'h73, v[7:0]);
  endtask
  task automatic set_alarm(input logic [31:0] v);
    wrb(8'h74, v[31:24]); wrb(8'h75, v[23:16]); wrb(8'h76, v[15:8]); wrb(8'h77, v[7:0]);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(40000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rdata == 8'h00, "R1 rdata reset", rdata, 0);
    check(irq == 1'b0, "R1 irq reset", irq, 0);
    rdb(8'h74, 8'hFF, "R1 alarm reset");
    rdb(8'h77, 8'hFF, "R1 alarm reset lsb");
    rdb(8'h29, 8'h00, "R1 control reset");
    rdb(8'h70, 8'h00, "R1 count reset");
    // R10 identification and unmapped space
    rdb(8'h00, 8'h5A, "R10 vendor");
    rdb(8'h01, 8'h41, "R10 model");
    rdb(8'h11, 8'h00, "R10 status2");
    rdb(8'h12, 8'h00, "R10 status3");
    wrb(8'h00, 8'h33);
    rdb(8'h00, 8'h5A, "R10 vendor after write");
    rdb(8'h05, 8'h00, "R10 unmapped");
    // R4 staged load, R3 snapshot, R2 advance
    wrb(8'h70, 8'h12); wrb(8'h71, 8'h34); wrb(8'h72, 8'h56);
    rdb(8'h70, 8'h00, "R4 staged bytes not live");
    wrb(8'h73, 8'h78);
    rdb(8'h70, 8'h12, "R3 msb");
    ticks(3);
    rdb(8'h71, 8'h34, "R3 snapshot b2");
    rdb(8'h72, 8'h56, "R3 snapshot b1");
    rdb(8'h73, 8'h78, "R3 snapshot b0");
    rdb(8'h70, 8'h12, "R2 msb after ticks");
    rdb(8'h73, 8'h7B, "R2 three ticks");
    // R4 load beats a simultaneous tick
    cyc(1, 1, 0, 8'h73, 8'h00);
    rdb(8'h70, 8'h12, "R4 load msb");
    rdb(8'h73, 8'h00, "R4 load over tick");
    // R2 wrap and R7 disabled alarm crossing all ones
    set_time(32'hFFFF_FFFE);
    ticks(2); idle();
    check(irq == 1'b0, "R7 no event through all ones", irq, 0);
    rdb(8'h70, 8'h00, "R2 wrap msb");
    rdb(8'h73, 8'h00, "R2 wrap lsb");
    // R9 control, R5 alarm bytes, R6 event
    wrb(8'h29, 8'h58);
    rdb(8'h29, 8'h58, "R9 control readback");
    set_alarm(32'h0000_0005);
    rdb(8'h74, 8'h00, "R5 alarm msb");
    rdb(8'h77, 8'h05, "R5 alarm lsb");
    ticks(4); idle();
    check(irq == 1'b0, "R6 no early event", irq, 0);
    ticks(1);
    check(irq == 1'b1, "R6 event on match", irq, 1);
    idle();
    check(n_wake == 1, "R9 wake pulse", n_wake, 1);
    check(n_pwr == 0, "R9 no pwrup when disabled", n_pwr, 0);
    rdb(8'h10, 8'h08, "R6 status bit3");
    // R8 write-one-to-clear
    wrb(8'h10, 8'h00);
    rdb(8'h10, 8'h08, "R8 zero write keeps");
    wrb(8'h10, 8'h08); idle();
    check(irq == 1'b0, "R8 cleared irq", irq, 0);
    rdb(8'h10, 8'h00, "R8 cleared status");
    // R9 power-up enable
    wrb(8'h29, 8'h04);
    set_time(32'h0000_0004);
    ticks(1); idle();
    check(n_pwr == 1, "R9 pwrup pulse", n_pwr, 1);
    check(n_wake == 1, "R9 wake gated off", n_wake, 1);
    wrb(8'h10, 8'h08);
    // R8 event beats a clear in the same cycle
    set_time(32'h0000_0004);
    cyc(1, 1, 0, 8'h10, 8'h08); idle();
    check(irq == 1'b1, "R8 set wins over clear", irq, 1);
    wrb(8'h10, 8'h08); idle();
    check(irq == 1'b0, "R8 clear after", irq, 0);
    // R7 alarm switched off
    set_alarm(32'hFFFF_FFFF);
    set_time(32'hFFFF_FFFD);
    ticks(4); idle();
    check(irq == 1'b0, "R7 disabled alarm", irq, 0);
    rdb(8'h74, 8'hFF, "R7 alarm readback");
    repeat (3) idle();
    finish_up();
  end
endmodule